// File: doc/BRIEF.md
# Floating-Point Status Register Field-Update Unit

This block owns the 32-bit floating-point status and control register and carries out the small set of instructions that read or rewrite it directly. One operation is presented per cycle as a decoded opcode, a few instruction fields and a 64-bit source operand. The register is updated on the next clock edge. Condition-register updates, the read result and the illegal-instruction flag are combinational outputs in the same cycle.

Bits and fields are numbered from the most significant end. Bit n is `fpsr[31-n]`, and field i is `fpsr[31-4i : 28-4i]`. A condition-register nibble is written as `{LT, GT, EQ, SO}`, with LT in bit 3 and SO in bit 0. Generation of arithmetic exceptions and the summary-bit rules belong to other logic.

Top module: `fpsr_field_unit`

## Requirements
- R1: While `rst_n` is low, the status register is cleared to 0.
- R2: Opcode 0 sets status bit `op_dst` and opcode 1 clears it. Bit n is register bit 31-n.
- R3: Opcode 2 is the masked write. For each field i from 0 to 7 with `op_mask[7-i]` set, field i is loaded from the same field of `src_val[31:0]`. Fields whose mask bit is clear keep their value.
- R4: Opcode 3 writes `op_imm` into field `op_dst[4:2]`.
- R5: Opcode 4 copies status field `op_a[4:2]` into condition field `op_dst[4:2]`. The unit drives `cr_we`=1, `cr_idx`=`op_dst[4:2]`, `cr_mask`=4'hF and `cr_data` equal to the field value before the update.
- R6: After the copy in R5, the unit clears sticky status bits chosen by the source field. The bit numbers use the R2 numbering:
  - source field 0 clears bits 0 and 3;
  - source field 1 clears bits 4 to 7;
  - source field 2 clears bits 8 to 11;
  - source field 3 clears bit 12;
  - source field 5 clears bit 23;
  - source fields 4, 6 and 7 clear nothing.
- R7: Opcodes 0 to 3 with `op_rec`=1 drive a condition update with `cr_idx`=1, `cr_mask`=4'b1110 and `cr_data`=0. This clears LT, GT and EQ and keeps SO. With `op_rec`=0 these opcodes make no condition update. For opcodes 4 and 5, `op_rec` has no effect.
- R8: Opcode 5 raises `rd_valid`. `rd_data` carries 32'hFFF80000 in the upper word and the status register in the lower word.
- R9: The operation is illegal, and `illegal` is raised, in any of these cases:
  - opcodes 6 and 7;
  - opcodes 0, 1 and 5 with a nonzero `op_a` or `op_b`;
  - opcode 2 with a nonzero `op_dst` or `op_a`;
  - opcode 3 with a nonzero `op_dst[1:0]`, `op_a` or `op_b`;
  - opcode 4 with a nonzero `op_dst[1:0]`, `op_a[1:0]` or `op_b`.

  An illegal operation leaves the register unchanged and raises neither `cr_we` nor `rd_valid`.
- R10: With `op_valid` low, nothing changes and no output strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select (0 set, 1 clear, 2 masked write, 3 immediate, 4 copy, 5 read) |
| op_dst | input | 5 | Bit index, or destination field in bits 4:2 |
| op_a | input | 5 | Source field in bits 4:2 for copy, otherwise reserved |
| op_b | input | 5 | Reserved, must be zero |
| op_mask | input | 8 | Field mask for the masked write |
| op_imm | input | 4 | Immediate nibble |
| op_rec | input | 1 | Record bit |
| src_val | input | 64 | Source operand; the low word is used |
| fpsr | output | 32 | Status register |
| cr_we | output | 1 | Condition field write strobe |
| cr_idx | output | 3 | Condition field index |
| cr_mask | output | 4 | Bits of the field to write |
| cr_data | output | 4 | Value for the written bits |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read result |
| illegal | output | 1 | Operation rejected |

## Verification
The register is visible on `fpsr` at all times, so a wrong field or bit placement shows one clock after the offending operation. A wrong sticky-clear mask shows up as a surviving one-bit in the register. A wrong copy source shows up on `cr_data` in the same cycle. Field-select mistakes are provoked by preloading the register with all ones and copying every field in turn. A missed illegal check shows as a register change or a condition strobe where none may occur.

// File: rtl/fpsr_field_unit.sv
module fpsr_field_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_code,
  input  logic [4:0]  op_dst,
  input  logic [4:0]  op_a,
  input  logic [4:0]  op_b,
  input  logic [7:0]  op_mask,
  input  logic [3:0]  op_imm,
  input  logic        op_rec,
  input  logic [63:0] src_val,
  output logic [31:0] fpsr,
  output logic        cr_we,
  output logic [2:0]  cr_idx,
  output logic [3:0]  cr_mask,
  output logic [3:0]  cr_data,
  output logic        rd_valid,
  output logic [63:0] rd_data,
  output logic        illegal
);
  localparam logic [2:0] OP_SET  = 3'd0;
  localparam logic [2:0] OP_CLR  = 3'd1;
  localparam logic [2:0] OP_MASK = 3'd2;
  localparam logic [2:0] OP_IMM  = 3'd3;
  localparam logic [2:0] OP_COPY = 3'd4;
  localparam logic [2:0] OP_READ = 3'd5;
  localparam logic [31:0] READ_HI = 32'hFFF8_0000;

  logic [31:0] fpsr_q, fpsr_d, sticky;
  logic        bad, act;
  logic        unused_src_hi;

  wire [2:0] dfld    = op_dst[4:2];
  wire [2:0] afld    = op_a[4:2];
  wire [3:0] src_nib = fpsr_q[31 - 4*afld -: 4];
  wire       is_copy = op_code == OP_COPY;

  assign unused_src_hi = ^src_val[63:32];

  always_comb begin
    case (op_code)
      OP_SET, OP_CLR, OP_READ: bad = |op_a || |op_b;
      OP_MASK: bad = |op_dst || |op_a;
      OP_IMM:  bad = |op_dst[1:0] || |op_a || |op_b;
      OP_COPY: bad = |op_dst[1:0] || |op_a[1:0] || |op_b;
      default: bad = 1'b1;
    endcase
  end

  assign act     = op_valid && !bad;
  assign illegal = op_valid && bad;

  always_comb begin
    case (afld)
      3'd0:    sticky = 32'h9000_0000;
      3'd1:    sticky = 32'h0F00_0000;
      3'd2:    sticky = 32'h00F0_0000;
      3'd3:    sticky = 32'h0008_0000;
      3'd5:    sticky = 32'h0000_0100;
      default: sticky = 32'h0;
    endcase
  end

  always_comb begin
    fpsr_d = fpsr_q;
    case (op_code)
      OP_SET:  fpsr_d[5'd31 - op_dst] = 1'b1;
      OP_CLR:  fpsr_d[5'd31 - op_dst] = 1'b0;
      OP_MASK:
        for (int i = 0; i < 8; i++)
          if (op_mask[7-i]) fpsr_d[31 - 4*i -: 4] = src_val[31 - 4*i -: 4];
      OP_IMM:  fpsr_d[31 - 4*dfld -: 4] = op_imm;
      OP_COPY: fpsr_d = fpsr_q & ~sticky;
      default: fpsr_d = fpsr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   fpsr_q <= '0;
    else if (act) fpsr_q <= fpsr_d;

  assign fpsr     = fpsr_q;
  assign cr_we    = act && (is_copy || (op_rec && op_code <= OP_IMM));
  assign cr_idx   = is_copy ? dfld : 3'd1;
  assign cr_mask  = is_copy ? 4'hF : 4'hE;
  assign cr_data  = is_copy ? src_nib : 4'h0;
  assign rd_valid = act && op_code == OP_READ;
  assign rd_data  = {READ_HI, fpsr_q};
endmodule

// File: rtl/fpsr_field_chk.sv
module fpsr_field_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic [4:0]  op_dst,
  input logic [4:0]  op_a,
  input logic        op_rec,
  input logic [31:0] fpsr,
  input logic        cr_we,
  input logic [2:0]  cr_idx,
  input logic [3:0]  cr_mask,
  input logic [3:0]  cr_data,
  input logic        rd_valid,
  input logic        illegal
);
  logic [31:0] clr_m;
  always_comb begin
    clr_m = 32'h0;
    if (op_a[4:2] == 3'd0) clr_m = 32'h9000_0000;
    if (op_a[4:2] == 3'd1) clr_m = 32'h0F00_0000;
    if (op_a[4:2] == 3'd2) clr_m = 32'h00F0_0000;
    if (op_a[4:2] == 3'd3) clr_m = 32'h0008_0000;
    if (op_a[4:2] == 3'd5) clr_m = 32'h0000_0100;
  end

  wire good = op_valid && !illegal;

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |=> fpsr == 32'h0);
  // R2
  set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good && op_code == 3'd0 |=> fpsr[5'd31 - $past(op_dst)]);
  // R2
  clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good && op_code == 3'd1 |=> !fpsr[5'd31 - $past(op_dst)]);
  // R6
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good && op_code == 3'd4 |=> (fpsr & $past(clr_m)) == 32'h0);
  // R7
  rec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good && op_rec && op_code <= 3'd3 |-> cr_we && cr_idx == 3'd1 && cr_mask == 4'hE && cr_data == 4'h0);
  // R9
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(fpsr));
  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !cr_we && !rd_valid);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(fpsr));
endmodule

bind fpsr_field_unit fpsr_field_chk i_chk (.*);

// File: tb/test_fpsr_field_unit.sv
module test_fpsr_field_unit;
  localparam time PERIOD = 10ns;

  logic clk = 0, rst_n = 0, op_valid = 0, op_rec = 0;
  logic [2:0] op_code = 0;
  logic [4:0] op_dst = 0, op_a = 0, op_b = 0;
  logic [7:0] op_mask = 0;
  logic [3:0] op_imm = 0;
  logic [63:0] src_val = 0;
  logic [31:0] fpsr;
  logic cr_we, rd_valid, illegal;
  logic [2:0] cr_idx;
  logic [3:0] cr_mask, cr_data;
  logic [63:0] rd_data;
  int checks = 0, fails = 0;

  fpsr_field_unit i_fpsr_field_unit (.*);

  always #(PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [2:0] op; logic [4:0] d, a, b; logic [7:0] m; logic [3:0] imm; logic rec;
    logic [31:0] src; logic ill, we; logic [2:0] idx; logic [3:0] cm, cd; logic [31:0] fp;
  } vec_t;

  localparam vec_t VT [24] = '{
    '{3'd0, 5'd0, 5'd0, 5'd0, 8'h00, 4'h0, 1'b1, 32'h0,        1'b0, 1'b1, 3'd1, 4'hE, 4'h0, 32'h8000_0000}, // R2 R7
    '{3'd0, 5'd31,5'd0, 5'd0, 8'h00, 4'h0, 1'b0, 32'h0,        1'b0, 1'b0, 3'd0, 4'h0, 4'h0, 32'h8000_0001}, // R2
    '{3'd1, 5'd0, 5'd0, 5'd0, 8'h00, 4'h0, 1'b0, 32'h0,        1'b0, 1'b0, 3'd0, 4'h0, 4'h0, 32'h0000_0001}, // R2
    '{3'd0, 5'd5, 5'd3, 5'd0, 8'h00, 4'h0, 1'b0, 32'h0,        1'b1, 1'b0, 3'd0, 4'h0, 4'h0, 32'h0000_0001}, // R9
    '{3'd2, 5'd0, 5'd0, 5'd0, 8'h81, 4'h0, 1'b1, 32'hABCD_1234,1'b0, 1'b1, 3'd1, 4'hE, 4'h0, 32'hA000_0004}, // R3 R7
    '{3'd2, 5'd0, 5'd0, 5'd0, 8'hFF, 4'h0, 1'b0, 32'h1234_5678,1'b0, 1'b0, 3'd0, 4'h0, 4'h0, 32'h1234_5678}, // R3
    '{3'd2, 5'd0, 5'd0, 5'd0, 8'h00, 4'h0, 1'b0, 32'hFFFF_FFFF,1'b0, 1'b0, 3'd0, 4'h0, 4'h0, 32'h1234_5678}, // R3
    '{3'd3, 5'd8, 5'd0, 5'd0, 8'h00, 4'hF, 1'b1, 32'h0,        1'b0, 1'b1, 3'd1, 4'hE, 4'h0, 32'h12F4_5678}, // R4 R7
    '{3'd3, 5'd9, 5'd0, 5'd0, 8'h00, 4'h3, 1'b0, 32'h0,        1'b1, 1'b0, 3'd0, 4'h0, 4'h0, 32'h12F4_5678}, // R9
    '{3'd2, 5'd0, 5'd1, 5'd0, 8'hFF, 4'h0, 1'b0, 32'h0,        1'b1, 1'b0, 3'd0, 4'h0, 4'h0, 32'h12F4_5678}, // R9
    '{3'd2, 5'd0, 5'd0, 5'd0, 8'hFF, 4'h0, 1'b0, 32'hFFFF_FFFF,1'b0, 1'b0, 3'd0, 4'h0, 4'h0, 32'hFFFF_FFFF}, // R3
    '{3'd4, 5'd24,5'd0, 5'd0, 8'h00, 4'h0, 1'b1, 32'h0,        1'b0, 1'b1, 3'd6, 4'hF, 4'hF, 32'h6FFF_FFFF}, // R5 R6 R7
    '{3'd4, 5'd0, 5'd4, 5'd0, 8'h00, 4'h0, 1'b0, 32'h0,        1'b0, 1'b1, 3'd0, 4'hF, 4'hF, 32'h60FF_FFFF}, // R6
    '{3'd4, 5'd4, 5'd8, 5'd0, 8'h00, 4'h0, 1'b0, 32'h0,        1'b0, 1'b1, 3'd1, 4'hF, 4'hF, 32'h600F_FFFF}, // R6
    '{3'd4, 5'd8, 5'd12,5'd0, 8'h00, 4'h0, 1'b0, 32'h0,        1'b0, 1'b1, 3'd2, 4'hF, 4'hF, 32'h6007_FFFF}, // R6
    '{3'd4, 5'd12,5'd16,5'd0, 8'h00, 4'h0, 1'b0, 32'h0,        1'b0, 1'b1, 3'd3, 4'hF, 4'hF, 32'h6007_FFFF}, // R6
    '{3'd4, 5'd16,5'd20,5'd0, 8'h00, 4'h0, 1'b0, 32'h0,        1'b0, 1'b1, 3'd4, 4'hF, 4'hF, 32'h6007_FEFF}, // R6
    '{3'd4, 5'd28,5'd0, 5'd0, 8'h00, 4'h0, 1'b0, 32'h0,        1'b0, 1'b1, 3'd7, 4'hF, 4'h6, 32'h6007_FEFF}, // R5
    '{3'd4, 5'd0, 5'd2, 5'd0, 8'h00, 4'h0, 1'b0, 32'h0,        1'b1, 1'b0, 3'd0, 4'h0, 4'h0, 32'h6007_FEFF}, // R9
    '{3'd4, 5'd0, 5'd0, 5'd1, 8'h00, 4'h0, 1'b0, 32'h0,        1'b1, 1'b0, 3'd0, 4'h0, 4'h0, 32'h6007_FEFF}, // R9
    '{3'd4, 5'd20,5'd28,5'd0, 8'h00, 4'h0, 1'b0, 32'h0,        1'b0, 1'b1, 3'd5, 4'hF, 4'hF, 32'h6007_FEFF}, // R5
    '{3'd5, 5'd0, 5'd0, 5'd0, 8'h00, 4'h0, 1'b1, 32'h0,        1'b0, 1'b0, 3'd0, 4'h0, 4'h0, 32'h6007_FEFF}, // R7
    '{3'd6, 5'd0, 5'd0, 5'd0, 8'h00, 4'h0, 1'b0, 32'h0,        1'b1, 1'b0, 3'd0, 4'h0, 4'h0, 32'h6007_FEFF}, // R9
    '{3'd1, 5'd1, 5'd0, 5'd0, 8'h00, 4'h0, 1'b1, 32'h0,        1'b0, 1'b1, 3'd1, 4'hE, 4'h0, 32'h2007_FEFF}  // R2 R7
  };

  task automatic chk(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op_code = v.op; op_dst = v.d; op_a = v.a; op_b = v.b; op_mask = v.m;
    op_imm = v.imm; op_rec = v.rec; src_val = {32'hDEAD_BEEF, v.src};
  endtask

  initial begin
    #(PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fpsr == 32'h0, "R1 reset", {32'h0, fpsr}, 64'h0);
    rst_n = 1;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      drive(VT[k]);
      op_valid = 1;
      #1;
      chk(illegal == VT[k].ill, "R9 illegal flag", {63'h0, illegal}, {63'h0, VT[k].ill});
      chk(cr_we == VT[k].we, "R5/R7 cr_we", {63'h0, cr_we}, {63'h0, VT[k].we});
      if (VT[k].we)
        chk({cr_idx, cr_mask, cr_data} == {VT[k].idx, VT[k].cm, VT[k].cd}, "R5/R7 cr fields",
            {53'h0, cr_idx, cr_mask, cr_data}, {53'h0, VT[k].idx, VT[k].cm, VT[k].cd});
      @(posedge clk);
      #1;
      op_valid = 0;
      chk(fpsr == VT[k].fp, "R2/R3/R4/R6/R9 fpsr", {32'h0, fpsr}, {32'h0, VT[k].fp});
    end
    // R8 read
    @(negedge clk);
    op_code = 3'd5; op_dst = 0; op_a = 0; op_b = 0; op_rec = 0; op_valid = 1;
    #1;
    chk(rd_valid, "R8 rd_valid", {63'h0, rd_valid}, 64'h1);
    chk(rd_data == 64'hFFF8_0000_2007_FEFF, "R8 rd_data", rd_data, 64'hFFF8_0000_2007_FEFF);
    // R9 illegal read
    op_a = 5'd1;
    #1;
    chk(!rd_valid && illegal, "R9 illegal read", {62'h0, rd_valid, illegal}, 64'h1);
    // R10 idle op
    @(negedge clk);
    op_valid = 0; op_code = 3'd0; op_a = 0; op_dst = 5'd2; op_rec = 1;
    #1;
    chk(!cr_we && !rd_valid && !illegal, "R10 idle strobes", {61'h0, cr_we, rd_valid, illegal}, 64'h0);
    @(posedge clk); #1;
    chk(fpsr == 32'h2007_FEFF, "R10 idle hold", {32'h0, fpsr}, 64'h2007_FEFF);
    // R1 reset mid-run
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(fpsr == 32'h0, "R1 mid reset", {32'h0, fpsr}, 64'h0);
    rst_n = 1;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule